// File: doc/BRIEF.md
# Push-Button Event Capture Register with Interrupt

This block is an input peripheral for a small 8-bit soft processor that reads its I/O through a port address, a read strobe and a returned data byte. It watches five push-button levels (select, down, up, left, right). It turns each new press into a sticky event held in one status byte. That byte carries an event flag and one bit for each button that caused the event. While the flag is set, the interrupt request line is high.

The processor clears the event in one of two ways. It can read the status byte with the read strobe at the block's port address, or it can acknowledge the interrupt. Either way the flag and the button bits drop together. Button levels come in already debounced. Inside the block they pass through a synchronizer and a rising-edge detector, so a button held down counts as one press.

Event tracking is a two-state machine. `ST_IDLE` means no event is pending and `ST_HELD` means an event is latched. The transitions are:
- **CAPTURE**: `ST_IDLE` to `ST_HELD` on any new press.
- **MERGE**: `ST_HELD` to `ST_HELD` on a further press with no clear.
- **REPLACE**: `ST_HELD` to `ST_HELD` when a press and a clear meet in the same cycle.
- **CLEAR**: `ST_HELD` to `ST_IDLE` on a read or an acknowledge with no press.
- **WAIT**: either state holding when nothing happens.

Top module: `btn_capture`

## Requirements
- R1: After reset the status byte reads 0x00 and `irq` is low.
- R2: Status layout: bit 7 is the event flag, bit 4 select, bit 3 down, bit 2 up, bit 1 left, bit 0 right, bits 6 and 5 always 0. The input `btn_lvl` uses the same order in bits 4..0.
- R3: A rising level on any button sets the flag and that button's bit. Both are visible, and `irq` is high, SYNC_STAGES+1 clock edges after the level changes.
- R4: A button held high makes one event only. After that event is cleared, the held level raises no new event.
- R5: A read (`rd_strobe` high with `port_id` equal to REG_ADDR) returns the status from before the clear on `rd_data` in that cycle. At that clock edge it clears the flag, all button bits and `irq`.
- R6: A high `int_ack` at a clock edge clears the flag, all button bits and `irq`, whatever the port address.
- R7: A read strobe with a different `port_id` clears nothing, and `rd_data` is 0x00 whenever `port_id` differs from REG_ADDR.
- R8: A new press while an event is pending ORs its bit into the pending bits and keeps the flag set.
- R9: A press whose edge meets a clear in the same cycle is not lost. After that edge the flag is set and the button bits hold only the new press.
- R10: With `port_id` equal to REG_ADDR and no read strobe, `rd_data` shows the status byte and nothing is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_lvl | input | 5 | Debounced button levels (bit 4 select .. bit 0 right) |
| port_id | input | PORT_W | Processor port address |
| rd_strobe | input | 1 | Processor read strobe |
| int_ack | input | 1 | Interrupt acknowledge |
| rd_data | output | 8 | Status byte when addressed, else 0 |
| irq | output | 1 | Interrupt request, high while an event is pending |

## Verification
A button change shows up in the status SYNC_STAGES+1 clock edges after it is driven: the synchronizer stages plus the capture register. The bench therefore waits exactly that many rising edges before it samples, on the following falling edge. `rd_data` is combinational from `port_id`, so read values are sampled shortly after `port_id` is driven in the same cycle. Clears take effect at the single rising edge that the strobe or acknowledge spans, and are checked on the next falling edge. The same-cycle press-and-clear case is timed so that the detected edge and the strobe meet at that edge.

// File: rtl/btn_capture_pkg.sv
package btn_capture_pkg;

    localparam int N_BTN = 5;

    localparam int BIT_RIGHT  = 0;
    localparam int BIT_LEFT   = 1;
    localparam int BIT_UP     = 2;
    localparam int BIT_DOWN   = 3;
    localparam int BIT_SELECT = 4;
    localparam int BIT_FLAG   = 7;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } cap_state_t;

    typedef enum logic [2:0] {
        EV_WAIT,
        EV_CAPTURE,
        EV_MERGE,
        EV_REPLACE,
        EV_CLEAR
    } cap_event_t;

endpackage

// File: rtl/btn_capture_sync.sv
module btn_capture_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/btn_capture_edge.sv
module btn_capture_edge #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = lvl[b] & ~lvl_q[b];
        end
    endgenerate

endmodule

// File: rtl/btn_capture_fsm.sv
module btn_capture_fsm
    import btn_capture_pkg::*;
#(
    parameter int WIDTH = N_BTN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise,
    input  logic             clr,
    output logic             active,
    output logic [WIDTH-1:0] btns
);

    cap_state_t       state_q, state_d;
    cap_event_t       ev;
    logic [WIDTH-1:0] btns_q, btns_d;
    logic             any_rise;

    assign any_rise = |rise;

    // transition selection
    always_comb begin
        ev = EV_WAIT;
        unique case (state_q)
            ST_IDLE: begin
                if (any_rise) ev = EV_CAPTURE;
            end
            ST_HELD: begin
                if (any_rise && clr) ev = EV_REPLACE;
                else if (clr)        ev = EV_CLEAR;
                else if (any_rise)   ev = EV_MERGE;
            end
            default: ev = EV_WAIT;
        endcase
    end

    // next state and next button bits
    always_comb begin
        state_d = state_q;
        btns_d  = btns_q;
        unique case (ev)
            EV_CAPTURE: begin
                state_d = ST_HELD;
                btns_d  = rise;
            end
            EV_MERGE: begin
                state_d = ST_HELD;
                btns_d  = btns_q | rise;
            end
            EV_REPLACE: begin
                state_d = ST_HELD;
                btns_d  = rise;
            end
            EV_CLEAR: begin
                state_d = ST_IDLE;
                btns_d  = '0;
            end
            default: begin
                state_d = state_q;
                btns_d  = btns_q;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            btns_q  <= '0;
        end else begin
            state_q <= state_d;
            btns_q  <= btns_d;
        end
    end

    // outputs
    always_comb begin
        active = 1'b0;
        btns   = btns_q;
        unique case (state_q)
            ST_IDLE: active = 1'b0;
            ST_HELD: active = 1'b1;
            default: active = 1'b0;
        endcase
    end

endmodule

// File: rtl/btn_capture_port.sv
module btn_capture_port #(
    parameter int          PORT_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h04
) (
    input  logic [PORT_W-1:0] port_id,
    input  logic              rd_strobe,
    input  logic              int_ack,
    input  logic [7:0]        status,
    output logic [7:0]        rd_data,
    output logic              clr
);

    localparam logic [PORT_W-1:0] ADDR_W = PORT_W'(REG_ADDR);

    logic hit;

    assign hit     = (port_id == ADDR_W);
    assign rd_data = hit ? status : 8'h00;
    assign clr     = (hit & rd_strobe) | int_ack;

endmodule

// File: rtl/btn_capture.sv
module btn_capture
    import btn_capture_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         PORT_W      = 8,
    parameter logic [7:0] REG_ADDR    = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BTN-1:0]  btn_lvl,
    input  logic [PORT_W-1:0] port_id,
    input  logic              rd_strobe,
    input  logic              int_ack,
    output logic [7:0]        rd_data,
    output logic              irq
);

    logic [N_BTN-1:0] lvl_sync;
    logic [N_BTN-1:0] rise_vec;
    logic [N_BTN-1:0] btn_bits;
    logic             flag;
    logic             clr_evt;
    logic [7:0]       status;

    btn_capture_sync #(.WIDTH(N_BTN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (btn_lvl),
        .dout  (lvl_sync)
    );

    btn_capture_edge #(.WIDTH(N_BTN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_sync),
        .rise  (rise_vec)
    );

    btn_capture_fsm #(.WIDTH(N_BTN)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise_vec),
        .clr    (clr_evt),
        .active (flag),
        .btns   (btn_bits)
    );

    always_comb begin
        status = 8'h00;
        status[BIT_FLAG] = flag;
        status[BIT_SELECT:BIT_RIGHT] = btn_bits;
    end

    btn_capture_port #(.PORT_W(PORT_W), .REG_ADDR(REG_ADDR)) u_port (
        .port_id   (port_id),
        .rd_strobe (rd_strobe),
        .int_ack   (int_ack),
        .status    (status),
        .rd_data   (rd_data),
        .clr       (clr_evt)
    );

    assign irq = flag;

endmodule

// File: rtl/btn_capture_chk.sv
module btn_capture_chk #(
    parameter int WIDTH = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       rd_data,
    input logic             irq,
    input logic [WIDTH-1:0] rise_vec,
    input logic             clr_evt,
    input logic [7:0]       status
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00 && rd_data[6:5] == 2'b00);

    a_r3_rise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_vec) |=> irq);

    a_r3_flag_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[4:0] != '0));

    a_r5_clear_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !(|rise_vec)) |=> (!irq && status == 8'h00));

    a_r5_idle_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (status[4:0] == '0));

    a_r8_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_evt) |=> ((status[4:0] & $past(status[4:0])) == $past(status[4:0])));

    a_r9_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && (|rise_vec)) |=> (irq && status[4:0] == $past(rise_vec)));

endmodule

bind btn_capture btn_capture_chk #(.WIDTH(btn_capture_pkg::N_BTN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .irq      (irq),
    .rise_vec (rise_vec),
    .clr_evt  (clr_evt),
    .status   (status)
);

// File: tb/btn_capture_tb.sv
module btn_capture_tb;

    localparam int         SYNC_STAGES = 2;
    localparam int         LAT         = SYNC_STAGES + 1;
    localparam logic [7:0] ADDR        = 8'h04;
    localparam logic [7:0] OTHER       = 8'h05;

    // {button mask, expected status}
    localparam logic [12:0] VEC [7] = '{
        {5'h01, 8'h81}, {5'h02, 8'h82}, {5'h04, 8'h84}, {5'h08, 8'h88},
        {5'h10, 8'h90}, {5'h06, 8'h86}, {5'h1F, 8'h9F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] btn_lvl = '0;
    logic [7:0] port_id = OTHER;
    logic       rd_strobe = 1'b0;
    logic       int_ack = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    btn_capture #(.SYNC_STAGES(SYNC_STAGES), .PORT_W(8), .REG_ADDR(ADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_lvl(btn_lvl), .port_id(port_id),
        .rd_strobe(rd_strobe), .int_ack(int_ack), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic peek(output logic [7:0] v);
        port_id = ADDR;
        #1 v = rd_data;
        port_id = OTHER;
    endtask

    task automatic press(input logic [4:0] lvl);
        @(negedge clk) btn_lvl = lvl;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_clear(output logic [7:0] v);
        @(negedge clk);
        port_id = ADDR; rd_strobe = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_strobe = 1'b0; port_id = OTHER;
    endtask

    task automatic release_all();
        @(negedge clk) btn_lvl = '0;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        peek(v); chk("R1 status", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // vector table: R2 layout, R3 capture, R10 peek, R5 read clear
        for (int i = 0; i < 7; i++) begin
            press(VEC[i][12:8]);
            peek(v); chk("R2/R3 status", v, VEC[i][7:0]);
            chk("R3 irq", {7'd0, irq}, 8'h01);
            chk("R10 peek no clear", {7'd0, irq}, 8'h01);
            read_clear(v); chk("R5 read value", v, VEC[i][7:0]);
            chk("R5 irq cleared", {7'd0, irq}, 8'h00);
            peek(v); chk("R5 status cleared", v, 8'h00);
            release_all();
        end

        // R4 held button: one event only
        press(5'h01);
        read_clear(v);
        repeat (10) @(negedge clk);
        chk("R4 irq held", {7'd0, irq}, 8'h00);
        peek(v); chk("R4 status held", v, 8'h00);
        release_all();

        // R6 acknowledge clears at any port address
        press(5'h08);
        @(negedge clk) int_ack = 1'b1;
        @(negedge clk) int_ack = 1'b0;
        chk("R6 irq", {7'd0, irq}, 8'h00);
        peek(v); chk("R6 status", v, 8'h00);
        release_all();

        // R7 strobe at other port
        press(5'h02);
        @(negedge clk) port_id = OTHER; rd_strobe = 1'b1;
        #1 chk("R7 other port data", rd_data, 8'h00);
        @(negedge clk) rd_strobe = 1'b0;
        chk("R7 irq kept", {7'd0, irq}, 8'h01);
        peek(v); chk("R7 status kept", v, 8'h82);
        read_clear(v);
        release_all();

        // R8 merge while pending
        press(5'h04);
        press(5'h14);
        peek(v); chk("R8 merged", v, 8'h94);
        chk("R8 irq", {7'd0, irq}, 8'h01);
        read_clear(v);
        release_all();

        // R9 press meets clear in same cycle
        press(5'h01);
        @(negedge clk) btn_lvl = 5'h09;
        repeat (SYNC_STAGES) @(posedge clk);
        @(negedge clk);
        port_id = ADDR; rd_strobe = 1'b1;
        #1 chk("R9 read value", rd_data, 8'h81);
        @(negedge clk) rd_strobe = 1'b0; port_id = OTHER;
        chk("R9 irq", {7'd0, irq}, 8'h01);
        peek(v); chk("R9 status", v, 8'h88);
        read_clear(v);
        release_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule